// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm Interrupt

This peripheral keeps wall-clock time as a 32-bit count of seconds. A one-cycle pulse on the tick input, delivered once per second by an external timebase, advances the count by one. Software can load a new time and program one alarm comparator. When the count steps onto the alarm value and the alarm is enabled, the block records the event in a sticky status flag and raises an interrupt request.

Registers are reached over a simple synchronous bus that carries a byte offset and a bank select. The core bank holds the status, interrupt configuration, time and alarm registers. It models a slow analogue macro: a core write is held for a fixed number of settle cycles before it takes effect, and the bus is never stalled. The wrapper bank sits next to the interrupt controller. It holds a pending bit and a mask bit for the alarm line, and these two bits gate the external request. Software clears the alarm in two places: a write-one-to-clear in the core status register and a write-zero in the wrapper pending bit.

Top module: `sec_rtc_alarm`

## Requirements
- R1: After reset every register in both banks reads 0 and `irq_out` is low.
- R2: Each cycle with `tick_1hz` high adds one to the time register. After a time write has taken effect, the next tick counts on from the loaded value.
- R3: A core-bank write takes effect exactly SETTLE_CYCLES clock edges after the edge that accepts it. Until then, reads return the old value.
- R4: A core-bank write that arrives while an earlier one is still settling is discarded.
- R5: On a tick whose incremented count equals the alarm register (core offset 0x10) while config bit 0 is 1, status bit 0 (core offset 0x0) and wrapper pending bit 0 are both set. This happens once per match, and later ticks do not set them again.
- R6: With config bit 0 (core offset 0x4) at 0, a count match sets neither status bit 0 nor wrapper pending bit 0.
- R7: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. Status bit 1 (reserved second alarm) always reads 0.
- R8: In the wrapper register at wrapper offset 0x8, writing 0 to bit 0 clears pending and writing 1 cannot set it. Mask bits 2 and 3 are read/write, and bit 1 reads 0.
- R9: `irq_out` is high exactly when wrapper pending bit 0 and mask bit 2 are both 1.
- R10: When an alarm event and a clearing write (a status write-one commit or a wrapper write-zero) fall on the same edge, the event wins and the flag stays set.
- R11: When a time-write commit and a tick fall on the same edge, the loaded value wins and that tick is dropped.
- R12: Config bits 1 (periodic enable) and 2 (one-second period select) are stored and read back, and they raise no alarm by themselves.
- R13: Read data appears on `bus_rdata` one edge after the read is presented and shows the register value from before that edge. The time register is at core offset 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_bank | input | 1 | 0 selects the core bank, 1 the wrapper bank |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Alarm interrupt request |

## Verification
On the same edge that a delayed status write-one commit is due, an alarm match can set that same status flag. The bench provokes this by issuing the clearing write SETTLE_CYCLES cycles ahead and pulsing the tick so that the count lands on the alarm at the commit edge. In that same cycle it also writes zero to the wrapper pending bit. The flag, the pending bit and `irq_out` must all read back set afterwards. A second collision lines up a time-load commit with a tick, and the count must equal the loaded value with no increment.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    // Word indices (byte offset >> 2) in the core bank
    localparam logic [2:0] IDX_STAT  = 3'd0;
    localparam logic [2:0] IDX_CFG   = 3'd1;
    localparam logic [2:0] IDX_TIME  = 3'd3;
    localparam logic [2:0] IDX_ALARM = 3'd4;
    // Word index in the wrapper bank
    localparam logic [2:0] IDX_WRAP  = 3'd2;

    typedef struct packed {
        logic sel_1hz;   // bit 2
        logic per_en;    // bit 1
        logic al_en;     // bit 0
    } irq_cfg_t;

    typedef struct packed {
        logic mask2;     // bit 3
        logic mask1;     // bit 2
        logic pend2;     // bit 1
        logic pend1;     // bit 0
    } wrap_reg_t;

    function automatic logic [2:0] word_of(input logic [7:0] byte_off);
        return byte_off[4:2];
    endfunction

endpackage

// File: rtl/rtc_write_settle.sv
module rtc_write_settle #(
    parameter int DW     = 32,
    parameter int IW     = 3,
    parameter int SETTLE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [IW-1:0] req_idx,
    input  logic [DW-1:0] req_data,
    output logic          commit,
    output logic [IW-1:0] commit_idx,
    output logic [DW-1:0] commit_data
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    logic          pend_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] data_q;

    assign commit      = pend_q && (cnt_q == '0);
    assign commit_idx  = idx_q;
    assign commit_data = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (!pend_q) begin
            if (req_valid) begin
                pend_q <= 1'b1;
                cnt_q  <= CW'(SETTLE - 1);
                idx_q  <= req_idx;
                data_q <= req_data;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            pend_q <= 1'b0;
        end
    end

    // R4
    held_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cnt_q != '0) |=> ($stable(data_q) && $stable(idx_q)));

    // R3
    settle_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cnt_q != '0) |=> (pend_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] alarm_val,
    input  logic          alarm_en,
    output logic [DW-1:0] count,
    output logic          alarm_evt
);
    logic [DW-1:0] count_q;
    logic [DW-1:0] count_nx;

    assign count_nx  = count_q + 1'b1;
    assign alarm_evt = tick && !load_en && alarm_en && (count_nx == alarm_val);
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (load_en) count_q <= load_val;
        else if (tick)    count_q <= count_nx;
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> (count_q == $past(count_q) + 1'b1));

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count_q == $past(load_val)));

endmodule

// File: rtl/rtc_irq_wrap.sv
module rtc_irq_wrap
    import sec_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  logic      wr_en,
    input  logic [3:0] wr_data,
    output wrap_reg_t state,
    output logic      irq
);
    wrap_reg_t r_q;
    wrap_reg_t wd;

    assign wd    = wrap_reg_t'(wr_data);
    assign state = r_q;
    assign irq   = r_q.pend1 && r_q.mask1;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q.pend2 <= 1'b0;
            if (evt)        r_q.pend1 <= 1'b1;
            else if (wr_en) r_q.pend1 <= r_q.pend1 && wd.pend1;
            if (wr_en) begin
                r_q.mask1 <= wd.mask1;
                r_q.mask2 <= wd.mask2;
            end
        end
    end

    // R10
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> r_q.pend1);

    // R8
    pend_only_from_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.pend1) |-> $past(evt));

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm
    import sec_rtc_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 5,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_bank,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IW = 3;

    logic [IW-1:0] word;
    logic          core_wr, wrap_wr, rd;

    assign word    = word_of(8'(bus_addr));
    assign core_wr = bus_valid && bus_write && !bus_bank;
    assign wrap_wr = bus_valid && bus_write && bus_bank && (word == IDX_WRAP);
    assign rd      = bus_valid && !bus_write;

    logic          cm_en;
    logic [IW-1:0] cm_idx;
    logic [DATA_W-1:0] cm_data;

    rtc_write_settle #(.DW(DATA_W), .IW(IW), .SETTLE(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst(rst),
        .req_valid(core_wr), .req_idx(word), .req_data(bus_wdata),
        .commit(cm_en), .commit_idx(cm_idx), .commit_data(cm_data)
    );

    irq_cfg_t          cfg_q;
    logic [DATA_W-1:0] alarm_q;
    logic              stat1_q;
    logic [DATA_W-1:0] time_cnt;
    logic              alarm_evt;

    rtc_time_core #(.DW(DATA_W)) u_time (
        .clk(clk), .rst(rst),
        .tick(tick_1hz),
        .load_en(cm_en && cm_idx == IDX_TIME),
        .load_val(cm_data),
        .alarm_val(alarm_q),
        .alarm_en(cfg_q.al_en),
        .count(time_cnt),
        .alarm_evt(alarm_evt)
    );

    wrap_reg_t wrap_st;

    rtc_irq_wrap u_wrap (
        .clk(clk), .rst(rst),
        .evt(alarm_evt),
        .wr_en(wrap_wr),
        .wr_data(bus_wdata[3:0]),
        .state(wrap_st),
        .irq(irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            alarm_q <= '0;
            stat1_q <= 1'b0;
        end else begin
            if (cm_en && cm_idx == IDX_CFG)   cfg_q   <= irq_cfg_t'(cm_data[2:0]);
            if (cm_en && cm_idx == IDX_ALARM) alarm_q <= cm_data;
            if (alarm_evt)
                stat1_q <= 1'b1;
            else if (cm_en && cm_idx == IDX_STAT && cm_data[0])
                stat1_q <= 1'b0;
        end
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (bus_bank) begin
            if (word == IDX_WRAP) rd_mux[3:0] = wrap_st;
        end else begin
            case (word)
                IDX_STAT:  rd_mux[0]   = stat1_q;
                IDX_CFG:   rd_mux[2:0] = cfg_q;
                IDX_TIME:  rd_mux      = time_cnt;
                IDX_ALARM: rd_mux      = alarm_q;
                default:   rd_mux      = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    // R6
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat1_q) |-> $past(cfg_q.al_en));

    // R7
    zero_write_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_en && cm_idx == IDX_STAT && !cm_data[0] && !alarm_evt) |=> $stable(stat1_q));

    // R10
    evt_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> stat1_q);

endmodule

// File: tb/sim_sec_rtc_alarm.sv
module sim_sec_rtc_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int S          = 8;
    localparam int DW         = 32;
    localparam int AW         = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick_1hz;
    logic          bus_valid, bus_write, bus_bank;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_rtc_alarm #(.DATA_W(DW), .ADDR_W(AW), .SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_bank(bus_bank),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    localparam logic [AW-1:0] O_STAT = 5'h00, O_CFG = 5'h04, O_TIME = 5'h0C,
                              O_ALARM = 5'h10, O_WRAP = 5'h08;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic bank, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_valid = 1; bus_write = 1; bus_bank = bank; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic wr_core_settled(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr(1'b0, a, d);
        repeat (S) @(negedge clk);
    endtask

    task automatic rd(input logic bank, input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_valid = 1; bus_write = 0; bus_bank = bank; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic rd_chk(input string req, input logic bank, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(bank, a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1;
            @(negedge clk);
            tick_1hz = 0;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 0, O_STAT, 0);
        rd_chk("R1 cfg", 0, O_CFG, 0);
        rd_chk("R1 time", 0, O_TIME, 0);
        rd_chk("R1 alarm", 0, O_ALARM, 0);
        rd_chk("R1 wrapper", 1, O_WRAP, 0);
        check("R1 irq", irq_out, 0);
    endtask

    task automatic t_count;
        wr(0, O_TIME, 100);
        repeat (S-1) @(negedge clk);
        rd_chk("R3 old value before settle", 0, O_TIME, 0);
        rd_chk("R3 new value after settle (R13)", 0, O_TIME, 100);
        ticks(3);
        rd_chk("R2 counts on from load", 0, O_TIME, 103);
    endtask

    task automatic t_overlap;
        wr(0, O_TIME, 200);
        wr(0, O_TIME, 300);
        repeat (S) @(negedge clk);
        rd_chk("R4 second write dropped", 0, O_TIME, 200);
        repeat (2*S) @(negedge clk);
        rd_chk("R4 still dropped later", 0, O_TIME, 200);
    endtask

    task automatic t_alarm;
        wr_core_settled(O_ALARM, 203);
        wr_core_settled(O_CFG, 1);
        wr(1, O_WRAP, 4);
        ticks(2);
        rd_chk("R5 no flag before match", 0, O_STAT, 0);
        check("R9 irq before match", irq_out, 0);
        ticks(1);
        rd_chk("R5 flag on match", 0, O_STAT, 1);
        rd_chk("R5 pending on match", 1, O_WRAP, 5);
        check("R9 irq on match", irq_out, 1);
        wr_core_settled(O_STAT, 0);
        rd_chk("R7 zero write keeps flag", 0, O_STAT, 1);
        wr_core_settled(O_STAT, 1);
        rd_chk("R7 write one clears", 0, O_STAT, 0);
        wr(1, O_WRAP, 4);
        rd_chk("R8 write zero clears pending", 1, O_WRAP, 4);
        check("R9 irq after clear", irq_out, 0);
        ticks(3);
        rd_chk("R5 fires once: status", 0, O_STAT, 0);
        rd_chk("R5 fires once: pending", 1, O_WRAP, 4);
        rd_chk("R13 time", 0, O_TIME, 206);
    endtask

    task automatic t_mask;
        wr(1, O_WRAP, 0);
        wr(1, O_WRAP, 1);
        rd_chk("R8 write one cannot set pending", 1, O_WRAP, 0);
        wr(1, O_WRAP, 8);
        rd_chk("R8 mask2 read/write", 1, O_WRAP, 8);
        wr(1, O_WRAP, 0);
        wr_core_settled(O_ALARM, 210);
        ticks(4);
        rd_chk("R9 pending while masked", 1, O_WRAP, 1);
        check("R9 masked irq low", irq_out, 0);
        wr(1, O_WRAP, 5);
        check("R9 unmask raises irq", irq_out, 1);
        wr(1, O_WRAP, 4);
        check("R9 clear lowers irq", irq_out, 0);
        wr_core_settled(O_STAT, 1);
    endtask

    task automatic t_noen;
        wr_core_settled(O_CFG, 6);
        rd_chk("R12 cfg periodic bits", 0, O_CFG, 6);
        wr_core_settled(O_ALARM, 215);
        ticks(5);
        rd_chk("R6 time at match", 0, O_TIME, 215);
        rd_chk("R6 no flag", 0, O_STAT, 0);
        rd_chk("R6 no pending", 1, O_WRAP, 4);
        check("R6 irq low", irq_out, 0);
    endtask

    task automatic t_race;
        wr_core_settled(O_CFG, 1);
        wr_core_settled(O_ALARM, 500);
        wr_core_settled(O_TIME, 499);
        wr(0, O_STAT, 1);
        repeat (S-1) @(negedge clk);
        // commit edge: status clear, wrapper clear and alarm match together
        tick_1hz = 1; bus_valid = 1; bus_write = 1; bus_bank = 1;
        bus_addr = O_WRAP; bus_wdata = 4;
        @(negedge clk);
        tick_1hz = 0; bus_valid = 0; bus_write = 0;
        rd_chk("R10 flag survives clear", 0, O_STAT, 1);
        rd_chk("R10 pending survives clear", 1, O_WRAP, 5);
        check("R10 irq high", irq_out, 1);
        wr(0, O_TIME, 700);
        repeat (S-1) @(negedge clk);
        ticks(1);
        rd_chk("R11 load wins over tick", 0, O_TIME, 700);
        ticks(1);
        rd_chk("R11 next tick counts", 0, O_TIME, 701);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; tick_1hz = 0; bus_valid = 0; bus_write = 0; bus_bank = 0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_count;
        t_overlap;
        t_alarm;
        t_mask;
        t_noen;
        t_race;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule